// File: doc/BRIEF.md
# SRAM Controller with Posted Write Buffer

This block sits between a 32-bit request/ready bus and an on-chip byte-addressed SRAM. It accepts byte, halfword and word transfers. Each access is folded onto its naturally aligned location. Write data from the bus is placed in the byte lanes that the size and low address bits select. Reads return the chosen byte or halfword right-justified and zero-extended.

Every write is parked in a one-entry posted-write buffer, so writes complete in the cycle they are presented and never insert wait states. The parked entry reaches the array only when a later write arrives or the flush input is raised. A read that targets the parked word sees the buffered bytes laid over the array contents. A reset empties the buffer without committing it, and leaves the array contents as they were. The write made just before a reset is therefore lost unless it was repeated, followed by a dummy write, or flushed.

Top module: `sram_wb_ctrl`

## Requirements
- R1: The size code is 0 for byte, 1 for halfword, and 2 or 3 for word. A word access ignores address bits 1:0. A halfword access ignores address bit 0.
- R2: An accepted write is held in the buffer and is not written to the array. It is committed only when a later write is accepted or flush_i is high.
- R3: While rst_ni is low, ready_o and rvalid_o are 0. A reset drops the pending write, so the array keeps its earlier contents for that location.
- R4: Two identical consecutive writes leave the data in the array, because the second write commits the first.
- R5: With no write in the same cycle, flush_i high commits and empties a pending write. With no pending write, flush_i has no effect.
- R6: ready_o is 1 in every cycle after the first clock edge following reset release. A write is accepted in every cycle it is presented.
- R7: A read whose aligned word matches the pending write returns the pending bytes in their strobed lanes and array bytes in the other lanes.
- R8: A commit changes only the byte lanes that the buffered write covered. A byte write uses lane addr[1:0]. A halfword write uses lanes 1:0 when addr[1] is 0 and lanes 3:2 when it is 1.
- R9: rvalid_o is 1 in exactly the cycle after an accepted read and holds the read result. A byte read returns the value in rdata_o[7:0] and a halfword read in rdata_o[15:0], with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request |
| we_i | input | 1 | 1 for write, 0 for read |
| size_i | input | 2 | Transfer size: 0 byte, 1 halfword, 2 or 3 word |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write value, right-justified |
| flush_i | input | 1 | Commit the pending write without a new write |
| ready_o | output | 1 | Request accepted in this cycle |
| rvalid_o | output | 1 | Read result valid |
| rdata_o | output | 32 | Read result, right-justified and zero-extended |

## Verification
The assertions check several properties on every cycle. ready_o must stay high once it has risen, and rvalid_o must follow exactly one cycle after each accepted read. Narrow read results must carry zero upper bits. A pending entry must stay parked and unchanged until a write or a flush, and the buffer must be empty when ready_o rises. Only the bench scenarios can show which data survives a reset after single, repeated, dummy and flushed writes. They also show the lane-exact merge and commit of partial writes, and the folding of misaligned addresses. A behavioural byte-level reference model that forgets its pending bytes on reset provides those checks.

// File: rtl/sram_wb_pkg.sv
package sram_wb_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned LANES = BUS_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WALT = 2'd3
  } size_e;

  function automatic logic [LANES-1:0] size_strb(size_e sz, logic [1:0] lo);
    case (sz)
      SZ_BYTE: return 4'b0001 << lo;
      SZ_HALF: return lo[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // replicate narrow data on every lane; the strobe picks the live one
  function automatic logic [BUS_W-1:0] place_wdata(size_e sz, logic [BUS_W-1:0] d);
    case (sz)
      SZ_BYTE: return {4{d[7:0]}};
      SZ_HALF: return {2{d[15:0]}};
      default: return d;
    endcase
  endfunction

  function automatic logic [BUS_W-1:0] pick_rdata(size_e sz, logic [1:0] lo,
                                                  logic [BUS_W-1:0] w);
    case (sz)
      SZ_BYTE: return {24'h0, w[{lo, 3'b000} +: 8]};
      SZ_HALF: return {16'h0, w[{lo[1], 4'b0000} +: 16]};
      default: return w;
    endcase
  endfunction
endpackage

// File: rtl/sram_wb_steer.sv
module sram_wb_steer
  import sram_wb_pkg::*;
(
  input  logic [1:0]       size_i,
  input  logic [1:0]       addr_lo_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [BUS_W-1:0] rword_i,
  output logic [LANES-1:0] wstrb_o,
  output logic [BUS_W-1:0] wlane_o,
  output logic [BUS_W-1:0] rdata_o
);
  size_e sz;
  assign sz      = size_e'(size_i);
  assign wstrb_o = size_strb(sz, addr_lo_i);
  assign wlane_o = place_wdata(sz, wdata_i);
  assign rdata_o = pick_rdata(sz, addr_lo_i, rword_i);
endmodule

// File: rtl/sram_wb_buf.sv
module sram_wb_buf
  import sram_wb_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             drain_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [BUS_W-1:0] data_i,
  input  logic [LANES-1:0] strb_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [BUS_W-1:0] data_o,
  output logic [LANES-1:0] strb_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      idx_o  <= '0;
      data_o <= '0;
      strb_o <= '0;
    end else if (load_i) begin
      vld_o  <= 1'b1;
      idx_o  <= idx_i;
      data_o <= data_i;
      strb_o <= strb_i;
    end else if (drain_i) begin
      vld_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/sram_wb_array.sv
module sram_wb_array
  import sram_wb_pkg::*;
#(
  parameter int unsigned IDX_W = 8,
  localparam int unsigned WORDS = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [LANES-1:0] wstrb_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [BUS_W-1:0] rdata_o
);
  // one byte-wide array per lane; contents survive reset
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_mem [WORDS];
    always_ff @(posedge clk_i) begin
      if (we_i && wstrb_i[g]) lane_mem[widx_i] <= wdata_i[8*g +: 8];
    end
    assign rdata_o[8*g +: 8] = lane_mem[ridx_i];
  end
endmodule

// File: rtl/sram_wb_ctrl.sv
module sram_wb_ctrl
  import sram_wb_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              flush_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [31:0]       rdata_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             ready_q;
  logic             wr_acc, rd_acc, mem_we;
  logic [IDX_W-1:0] idx;
  logic [LANES-1:0] new_strb;
  logic [BUS_W-1:0] new_data, arr_word, merged, rd_val;
  logic             buf_vld, buf_hit;
  logic [IDX_W-1:0] buf_idx;
  logic [BUS_W-1:0] buf_data;
  logic [LANES-1:0] buf_strb;
  logic             rvalid_q;
  logic [BUS_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ready_q <= 1'b0;
    else         ready_q <= 1'b1;
  end

  assign idx    = addr_i[ADDR_W-1:2];
  assign wr_acc = req_i & ready_q & we_i;
  assign rd_acc = req_i & ready_q & ~we_i;
  // the parked entry drains on the next write or on flush
  assign mem_we = buf_vld & (wr_acc | flush_i);

  sram_wb_steer u_steer (
    .size_i   (size_i),
    .addr_lo_i(addr_i[1:0]),
    .wdata_i  (wdata_i),
    .rword_i  (merged),
    .wstrb_o  (new_strb),
    .wlane_o  (new_data),
    .rdata_o  (rd_val)
  );

  sram_wb_buf #(.IDX_W(IDX_W)) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wr_acc),
    .drain_i(flush_i),
    .idx_i  (idx),
    .data_i (new_data),
    .strb_i (new_strb),
    .vld_o  (buf_vld),
    .idx_o  (buf_idx),
    .data_o (buf_data),
    .strb_o (buf_strb)
  );

  sram_wb_array #(.IDX_W(IDX_W)) u_array (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .widx_i (buf_idx),
    .wstrb_i(buf_strb),
    .wdata_i(buf_data),
    .ridx_i (idx),
    .rdata_o(arr_word)
  );

  assign buf_hit = buf_vld & (buf_idx == idx);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign merged[8*g +: 8] = (buf_hit && buf_strb[g]) ? buf_data[8*g +: 8]
                                                      : arr_word[8*g +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_acc;
      if (rd_acc) rdata_q <= rd_val;
    end
  end

  assign ready_o  = ready_q;
  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/sram_wb_ctrl_chk.sv
module sram_wb_ctrl_chk #(
  parameter int unsigned IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [1:0]       size_i,
  input logic             flush_i,
  input logic             ready_o,
  input logic             rvalid_o,
  input logic [31:0]      rdata_o,
  input logic             buf_vld,
  input logic [IDX_W-1:0] buf_idx
);
  a_r6_ready_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  a_r9_rvalid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && !we_i) |=> rvalid_o);

  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && ready_o && !we_i) |=> !rvalid_o);

  a_r9_byte_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && !we_i && size_i == 2'd0) |=> (rdata_o[31:8] == 24'h0));

  a_r3_empty_at_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> !buf_vld);

  a_r2_write_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && ready_o) |=> buf_vld);

  a_r2_hold_until_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_vld && !(req_i && we_i && ready_o) && !flush_i) |=> (buf_vld && $stable(buf_idx)));

  a_r5_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !(req_i && we_i && ready_o)) |=> !buf_vld);
endmodule

bind sram_wb_ctrl sram_wb_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .size_i  (size_i),
  .flush_i (flush_i),
  .ready_o (ready_o),
  .rvalid_o(rvalid_o),
  .rdata_o (rdata_o),
  .buf_vld (buf_vld),
  .buf_idx (buf_idx)
);

// File: tb/sram_wb_ctrl_tb.sv
`timescale 1ns/1ps
module sram_wb_ctrl_tb;
  localparam int ADDR_W = 10;
  localparam int NBYTES = 1 << ADDR_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic              we_i = 1'b0;
  logic [1:0]        size_i = 2'd0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0]       wdata_i = '0;
  logic              flush_i = 1'b0;
  logic              ready_o, rvalid_o;
  logic [31:0]       rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference: committed bytes plus a queue of not-yet-committed bytes
  logic [7:0] ref_mem [int];
  int         pend_a[$];
  logic [7:0] pend_v[$];
  logic [31:0] last_rd;

  always #2.5 clk_i = ~clk_i;

  sram_wb_ctrl #(.ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .size_i(size_i), .addr_i(addr_i), .wdata_i(wdata_i), .flush_i(flush_i),
    .ready_o(ready_o), .rvalid_o(rvalid_o), .rdata_o(rdata_o)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic int span(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [7:0] ref_byte(input int a);
    for (int i = pend_a.size() - 1; i >= 0; i--)
      if (pend_a[i] == a) return pend_v[i];
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  function automatic logic [31:0] ref_read(input int a, input logic [1:0] sz);
    int n = span(sz);
    int base = a - (a % n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v[8*i +: 8] = ref_byte(base + i);
    return v;
  endfunction

  task automatic ref_commit();
    while (pend_a.size() > 0) begin
      ref_mem[pend_a.pop_front()] = pend_v.pop_front();
    end
  endtask

  // one bus cycle; inputs driven 1 ns after the edge, outputs sampled there
  task automatic step(input bit rq, input bit w, input logic [1:0] sz, input int a,
                      input logic [31:0] d, input bit fl, input string tag);
    bit          exp_v = rq && !w;
    logic [31:0] exp_d = exp_v ? ref_read(a, sz) : 32'h0;
    req_i = rq; we_i = w; size_i = sz; addr_i = ADDR_W'(a); wdata_i = d; flush_i = fl;
    @(posedge clk_i); #1;
    if (rq && w) begin
      int n = span(sz);
      int base = a - (a % n);
      ref_commit();
      for (int i = 0; i < n; i++) begin
        pend_a.push_back(base + i);
        pend_v.push_back(d[8*i +: 8]);
      end
    end else if (fl) begin
      ref_commit();
    end
    req_i = 1'b0; we_i = 1'b0; flush_i = 1'b0;
    chk(ready_o == 1'b1, {"R6 ready ", tag}, 32'(ready_o), 32'h1);
    chk(rvalid_o == exp_v, {"R9 rvalid ", tag}, 32'(rvalid_o), 32'(exp_v));
    if (exp_v) begin
      chk(rdata_o == exp_d, {"R9 rdata ", tag}, rdata_o, exp_d);
      last_rd = rdata_o;
    end
  endtask

  task automatic wr(input int a, input logic [1:0] sz, input logic [31:0] d, input string tag);
    step(1'b1, 1'b1, sz, a, d, 1'b0, tag);
  endtask

  task automatic rd(input int a, input logic [1:0] sz, input string tag);
    step(1'b1, 1'b0, sz, a, 32'h0, 1'b0, tag);
  endtask

  task automatic fl(input string tag);
    step(1'b0, 1'b0, 2'd0, 0, 32'h0, 1'b1, tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    req_i = 1'b0; flush_i = 1'b0;
    pend_a.delete(); pend_v.delete();
    repeat (2) @(posedge clk_i);
    #1;
    chk(ready_o == 1'b0, "R3 ready low in reset", 32'(ready_o), 32'h0);
    chk(rvalid_o == 1'b0, "R3 rvalid low in reset", 32'(rvalid_o), 32'h0);
    rst_ni = 1'b1;
    step(1'b0, 1'b0, 2'd0, 0, 32'h0, 1'b0, "R3 idle after reset");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    chk(ready_o == 1'b0, "R3 ready at time zero", 32'(ready_o), 32'h0);
    do_reset();

    // fill the array with zeros through back-to-back writes
    for (int w = 0; w < NBYTES / 4; w++) wr(w * 4, 2'd2, 32'h0, "R6 init fill");
    fl("R5 init flush");

    // R1 R7: misaligned word write, reads folded onto the same word
    wr(32'h13, 2'd2, 32'h11223344, "R1 word write at 0x13");
    rd(32'h12, 2'd2, "R7 forward word");
    chk(last_rd == 32'h11223344, "R7 forwarded word", last_rd, 32'h11223344);
    rd(32'h11, 2'd1, "R1 half at 0x11");
    chk(last_rd == 32'h00003344, "R1 half folded", last_rd, 32'h00003344);
    rd(32'h13, 2'd0, "R9 byte lane 3");
    chk(last_rd == 32'h00000011, "R9 byte zero-extended", last_rd, 32'h00000011);

    // R3: single write lost over reset
    do_reset();
    rd(32'h10, 2'd2, "R3 lost write");
    chk(last_rd == 32'h0, "R3 pending write dropped", last_rd, 32'h0);

    // R4: identical pair survives reset
    wr(32'h20, 2'd2, 32'hA5A50F0F, "R4 first");
    wr(32'h20, 2'd2, 32'hA5A50F0F, "R4 second");
    do_reset();
    rd(32'h20, 2'd2, "R4 after reset");
    chk(last_rd == 32'hA5A50F0F, "R4 pair committed", last_rd, 32'hA5A50F0F);

    // R5: flush commits; flush with nothing pending changes nothing
    wr(32'h30, 2'd2, 32'hCAFEBABE, "R5 write");
    fl("R5 flush");
    do_reset();
    fl("R5 empty flush");
    rd(32'h30, 2'd2, "R5 after reset");
    chk(last_rd == 32'hCAFEBABE, "R5 flushed data kept", last_rd, 32'hCAFEBABE);
    rd(32'h20, 2'd2, "R5 neighbour untouched");
    chk(last_rd == 32'hA5A50F0F, "R5 empty flush no effect", last_rd, 32'hA5A50F0F);

    // R7 R8: partial writes merge on read and commit only their lanes
    wr(32'h21, 2'd0, 32'hFFFFFF77, "R8 byte lane 1");
    rd(32'h20, 2'd2, "R7 merged byte");
    chk(last_rd == 32'hA5A5770F, "R7 byte merged", last_rd, 32'hA5A5770F);
    wr(32'h33, 2'd1, 32'h1234BEEF, "R8 half lanes 3:2");
    rd(32'h30, 2'd2, "R7 merged half");
    chk(last_rd == 32'hBEEFBABE, "R7 half merged", last_rd, 32'hBEEFBABE);
    fl("R8 flush half");
    do_reset();
    rd(32'h20, 2'd2, "R8 byte commit");
    chk(last_rd == 32'hA5A5770F, "R8 only lane 1 changed", last_rd, 32'hA5A5770F);
    rd(32'h30, 2'd2, "R8 half commit");
    chk(last_rd == 32'hBEEFBABE, "R8 only lanes 3:2 changed", last_rd, 32'hBEEFBABE);

    // R1: size code 3 behaves as word
    wr(32'h43, 2'd3, 32'h01020304, "R1 size3 write");
    rd(32'h41, 2'd3, "R1 size3 read");
    chk(last_rd == 32'h01020304, "R1 size3 as word", last_rd, 32'h01020304);

    // R7: other word not forwarded
    wr(32'h50, 2'd2, 32'hDEADBEEF, "R7 write 0x50");
    rd(32'h54, 2'd2, "R7 no forward");
    chk(last_rd == 32'h0, "R7 other word from array", last_rd, 32'h0);

    // R2: a pending write stays out of the array until a later write
    wr(32'h60, 2'd2, 32'h5A5A5A5A, "R2 park");
    rd(32'h64, 2'd2, "R2 idle read");
    rd(32'h60, 2'd2, "R2 forward");
    do_reset();
    rd(32'h60, 2'd2, "R2 not committed by read");
    chk(last_rd == 32'h0, "R2 reads do not commit", last_rd, 32'h0);

    // mixed traffic on a small window
    for (int k = 0; k < 1500; k++) begin
      int r = $urandom_range(0, 99);
      int a = $urandom_range(0, 63);
      logic [1:0] sz = 2'($urandom_range(0, 3));
      if (r < 55)      wr(a, sz, $urandom(), "R2 mixed write");
      else if (r < 90) rd(a, sz, "R7 mixed read");
      else if (r < 97) fl("R5 mixed flush");
      else if (r < 99) step(1'b0, 1'b0, 2'd0, 0, 32'h0, 1'b0, "R6 mixed idle");
      else             do_reset();
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule